// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

This block watches a received Ethernet frame one byte per accepted cycle and raises a wake indication when the frame carries a magic packet for the station's own 48-bit MAC address. A magic packet has a synchronization run of six consecutive 0xFF bytes followed at once by sixteen back-to-back copies of the station address. The run may sit anywhere in the frame, and the destination address type does not matter. A frame is only credited at its end, and only when the receive path reports a good CRC for it.

The receive path upstream supplies the byte stream with a valid strobe, start-of-frame and end-of-frame markers, and a CRC-good flag on the last byte. Power management software supplies the programmed address, a magic-packet enable bit and the current power state. The wake indication is sticky. It stays set until the power controller pulses the clear input. If a copy of the address is broken, the matcher does not resume counting. It goes back to hunting for a fresh six-byte sync later in the same frame.

Top module: `wol_magic_detect`

## Requirements
- R1: While rst_ni is low, and on the first cycles after it rises, wake_o is 0.
- R2: A frame that contains six consecutive 0xFF bytes followed at once by sixteen copies of the address sets wake_o in the cycle after its end-of-frame byte is accepted. Each copy is sent byte 0 first, and byte 0 is mac_i[47:40].
- R3: Fewer than six 0xFF bytes before the copies, or fewer than sixteen complete copies after the sync, gives no wake.
- R4: Extra 0xFF bytes beyond six, arriving just before the first copy, are absorbed into the sync and do not stop detection.
- R5: A byte that breaks the run of copies sends the matcher back to hunting for a new six-byte 0xFF sync. Copies that follow without a new sync give no wake. A new sync and sixteen copies later in the same frame do give a wake.
- R6: The magic sequence is found at any byte offset in the frame, whatever the destination address, including multicast.
- R7: A frame whose end-of-frame byte carries crc_ok_i = 0 never sets wake_o.
- R8: pwr_state_i is sampled with the end-of-frame byte. 2'b00 (full power) allows a wake only when mp_en_i = 1. 2'b01 (standby) allows a wake whatever mp_en_i holds. 2'b10 and 2'b11 never allow a wake.
- R9: All match progress is discarded at each start-of-frame byte, so a sequence split across two frames gives no wake.
- R10: wake_o holds until wake_clr_i is sampled high, and is 0 in the following cycle. If a wake is detected in the same cycle as a clear, the wake wins.
- R11: When valid_i is 0, data_i, sof_i, eof_i and crc_ok_i have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | data_i and the frame markers are valid this cycle |
| sof_i | input | 1 | Byte is the first of a frame |
| eof_i | input | 1 | Byte is the last of a frame |
| data_i | input | 8 | Received byte |
| crc_ok_i | input | 1 | Frame CRC good, sampled with the end-of-frame byte |
| mac_i | input | 48 | Station address, mac_i[47:40] sent first |
| mp_en_i | input | 1 | Magic packet enable for full-power state |
| pwr_state_i | input | 2 | 00 full, 01 standby, 10/11 other |
| wake_clr_i | input | 1 | Clears the sticky wake flag |
| wake_o | output | 1 | Sticky wake indication |

## Verification
The bench aims at the places where a sequence matcher tends to go wrong. It breaks a copy and then sends sixteen good copies without a new sync. A design that only rewinds its copy counter would wake on that frame. It sends nine 0xFF bytes before the copies, five-byte syncs and fifteen-copy runs. Off-by-one counters or a matcher that fails on surplus sync bytes show up there as missing or spurious wakes. It also splits a sequence over two frames, keeps junk on the inputs while valid is low, and raises clear in the same cycle as a detecting end of frame. These catch state that survives start of frame, markers that are not qualified by valid, and clear taking priority over set. Random frames cover every power state and enable value, and a pattern-search model computes the expected result.

// File: rtl/wol_pkg.sv
package wol_pkg;
  typedef enum logic [1:0] {
    PWR_FULL    = 2'b00,
    PWR_STANDBY = 2'b01,
    PWR_DEEP_A  = 2'b10,
    PWR_DEEP_B  = 2'b11
  } pwr_state_e;

  typedef enum logic [1:0] {
    ST_HUNT = 2'b00,
    ST_ADDR = 2'b01,
    ST_DONE = 2'b10
  } match_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'hFF;
endpackage

// File: rtl/wol_power_gate.sv
module wol_power_gate
  import wol_pkg::*;
(
  input  logic [1:0] pwr_state_i,
  input  logic       mp_en_i,
  output logic       armed_o
);
  pwr_state_e ps;

  always_comb begin
    ps = pwr_state_e'(pwr_state_i);
    unique case (ps)
      PWR_FULL:    armed_o = mp_en_i;
      PWR_STANDBY: armed_o = 1'b1;
      default:     armed_o = 1'b0;
    endcase
  end

  always_comb begin
    if (pwr_state_i[1]) a_r8_deep_disarmed : assert (!armed_o);
  end
endmodule

// File: rtl/wol_seq_match.sv
module wol_seq_match
  import wol_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16,
  parameter int ADDR_BYTES = 6,
  localparam int FW = $clog2(SYNC_LEN + 1),
  localparam int IW = $clog2(ADDR_BYTES),
  localparam int CW = $clog2(COPIES),
  localparam int MW = 8 * ADDR_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sof_i,
  input  logic [7:0]    data_i,
  input  logic [MW-1:0] mac_i,
  output logic          hit_next_o
);
  match_state_e st_q, st_d, st_b;
  logic [FW-1:0] ff_q, ff_d, ff_b;
  logic [IW-1:0] idx_q, idx_d, idx_b;
  logic [CW-1:0] cp_q, cp_d, cp_b;
  logic [7:0]    mac_byte;
  logic          byte_hit;
  logic          at_start;

  // base state: a start-of-frame byte is matched from a clean slate
  always_comb begin
    st_b  = st_q;
    ff_b  = ff_q;
    idx_b = idx_q;
    cp_b  = cp_q;
    if (sof_i) begin
      st_b  = ST_HUNT;
      ff_b  = '0;
      idx_b = '0;
      cp_b  = '0;
    end
  end

  always_comb begin
    mac_byte = '0;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (idx_b == IW'(k)) mac_byte = mac_i[8*(ADDR_BYTES-1-k) +: 8];
    end
  end

  assign byte_hit = (data_i == mac_byte);
  assign at_start = (idx_b == '0) && (cp_b == '0);

  always_comb begin
    st_d  = st_q;
    ff_d  = ff_q;
    idx_d = idx_q;
    cp_d  = cp_q;
    if (valid_i) begin
      st_d  = st_b;
      ff_d  = ff_b;
      idx_d = idx_b;
      cp_d  = cp_b;
      unique case (st_b)
        ST_HUNT: begin
          if (data_i == SYNC_BYTE) begin
            if (ff_b == FW'(SYNC_LEN - 1)) begin
              st_d  = ST_ADDR;
              ff_d  = '0;
              idx_d = '0;
              cp_d  = '0;
            end else begin
              ff_d = ff_b + 1'b1;
            end
          end else begin
            ff_d = '0;
          end
        end
        ST_ADDR: begin
          if (byte_hit) begin
            if (idx_b == IW'(ADDR_BYTES - 1)) begin
              idx_d = '0;
              if (cp_b == CW'(COPIES - 1)) st_d = ST_DONE;
              else                         cp_d = cp_b + 1'b1;
            end else begin
              idx_d = idx_b + 1'b1;
            end
          end else if (at_start && data_i == SYNC_BYTE) begin
            st_d = ST_ADDR;  // surplus sync byte
          end else begin
            st_d  = ST_HUNT;
            idx_d = '0;
            cp_d  = '0;
            ff_d  = (data_i == SYNC_BYTE) ? FW'(1) : '0;
          end
        end
        default: st_d = ST_DONE;
      endcase
    end
  end

  assign hit_next_o = (st_d == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HUNT;
      ff_q  <= '0;
      idx_q <= '0;
      cp_q  <= '0;
    end else begin
      st_q  <= st_d;
      ff_q  <= ff_d;
      idx_q <= idx_d;
      cp_q  <= cp_d;
    end
  end

  a_r2_idx_in_range : assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IW'(ADDR_BYTES - 1));
  a_r3_sync_in_range : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ff_q < FW'(SYNC_LEN));
  a_r9_sof_clears : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i) |=> (st_q == ST_HUNT && ff_q <= FW'(1)));
  a_r5_break_rehunt : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sof_i && st_q == ST_ADDR && (idx_q != '0 || cp_q != '0)
     && data_i != mac_byte) |=> (st_q == ST_HUNT));
  a_r11_idle_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(st_q) && $stable(cp_q) && $stable(idx_q));
endmodule

// File: rtl/wol_wake_flag.sv
module wol_wake_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic wake_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wake_o <= 1'b0;
    else if (set_i)  wake_o <= 1'b1;
    else if (clr_i)  wake_o <= 1'b0;
  end

  a_r10_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !clr_i) |=> wake_o);
  a_r10_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !wake_o);
  a_r10_set_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> wake_o);
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect #(
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16,
  parameter int ADDR_BYTES = 6,
  localparam int MW = 8 * ADDR_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sof_i,
  input  logic          eof_i,
  input  logic [7:0]    data_i,
  input  logic          crc_ok_i,
  input  logic [MW-1:0] mac_i,
  input  logic          mp_en_i,
  input  logic [1:0]    pwr_state_i,
  input  logic          wake_clr_i,
  output logic          wake_o
);
  logic armed;
  logic hit_next;
  logic wake_set;

  wol_power_gate u_gate (
    .pwr_state_i (pwr_state_i),
    .mp_en_i     (mp_en_i),
    .armed_o     (armed)
  );

  wol_seq_match #(
    .SYNC_LEN   (SYNC_LEN),
    .COPIES     (COPIES),
    .ADDR_BYTES (ADDR_BYTES)
  ) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .sof_i      (sof_i),
    .data_i     (data_i),
    .mac_i      (mac_i),
    .hit_next_o (hit_next)
  );

  assign wake_set = valid_i && eof_i && crc_ok_i && armed && hit_next;

  wol_wake_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wake_set),
    .clr_i  (wake_clr_i),
    .wake_o (wake_o)
  );

  a_r7_rise_needs_good_eof : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(valid_i && eof_i && crc_ok_i));
  a_r8_rise_needs_power : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(pwr_state_i == 2'b01 || (pwr_state_i == 2'b00 && mp_en_i)));
endmodule

// File: tb/tb_wol_magic_detect.sv
module tb_wol_magic_detect;
  localparam int SYNC = 6;
  localparam int NCOPY = 16;
  localparam int MAXF = 400;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, sof_i = 1'b0, eof_i = 1'b0, crc_ok_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [47:0] mac_i = 48'h0011_2233_4455;
  logic        mp_en_i = 1'b1;
  logic [1:0]  pwr_state_i = 2'b00;
  logic        wake_clr_i = 1'b0;
  logic        wake_o;

  int tests = 0, fails = 0;
  logic [7:0] fb [0:MAXF-1];
  int flen = 0;
  int seed;

  always #2 clk_i = ~clk_i;

  wol_magic_detect dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i), .eof_i(eof_i),
    .data_i(data_i), .crc_ok_i(crc_ok_i), .mac_i(mac_i), .mp_en_i(mp_en_i),
    .pwr_state_i(pwr_state_i), .wake_clr_i(wake_clr_i), .wake_o(wake_o)
  );

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [7:0] mbyte(int k);
    return mac_i[47-8*k -: 8];
  endfunction

  function automatic bit model_hit();
    for (int j = SYNC; j + 6*NCOPY <= flen; j++) begin
      bit ok = 1'b1;
      for (int k = 1; k <= SYNC; k++) if (fb[j-k] != 8'hFF) ok = 1'b0;
      for (int c = 0; c < 6*NCOPY; c++) if (fb[j+c] != mbyte(c % 6)) ok = 1'b0;
      if (ok) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic bit model_armed(logic [1:0] ps, logic en);
    return (ps == 2'b01) || (ps == 2'b00 && en);
  endfunction

  task automatic chk(bit got, bit exp, string req);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: wake_o=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    if (flen < MAXF) begin fb[flen] = b; flen++; end
  endtask
  task automatic put_rand(int n);
    for (int i = 0; i < n; i++)
      put(($urandom_range(0, 15) == 0) ? 8'hFF : 8'($urandom_range(0, 254)));
  endtask
  task automatic put_ff(int n);
    for (int i = 0; i < n; i++) put(8'hFF);
  endtask
  task automatic put_copies(int n);
    for (int c = 0; c < n; c++) for (int k = 0; k < 6; k++) put(mbyte(k));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      data_i = 8'($urandom);
      sof_i = 1'($urandom);
      eof_i = 1'($urandom);
      crc_ok_i = 1'($urandom);
    end
  endtask

  task automatic send(bit crc, bit gaps, bit clr_eof);
    for (int i = 0; i < flen; i++) begin
      if (gaps && $urandom_range(0, 3) == 0) idle(1);
      @(negedge clk_i);
      valid_i = 1'b1;
      data_i = fb[i];
      sof_i = (i == 0);
      eof_i = (i == flen - 1);
      crc_ok_i = (i == flen - 1) ? crc : 1'($urandom);
      wake_clr_i = clr_eof && (i == flen - 1);
    end
    @(negedge clk_i);
    valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0; wake_clr_i = 1'b0;
  endtask

  task automatic clear_wake();
    @(negedge clk_i); wake_clr_i = 1'b1;
    @(negedge clk_i); wake_clr_i = 1'b0;
  endtask

  task automatic run(bit crc, string req);
    bit exp;
    clear_wake();
    exp = model_hit() && crc && model_armed(pwr_state_i, mp_en_i);
    send(crc, 1'b1, 1'b0);
    chk(wake_o, exp, req);
  endtask

  task automatic magic_frame(int pre, int nff, int ncp, int post);
    flen = 0; put_rand(pre); put_ff(nff); put_copies(ncp); put_rand(post);
  endtask

  initial begin
    bit prev;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    chk(wake_o, 1'b0, "R1 in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(wake_o, 1'b0, "R1 after reset");

    // R11: full magic sequence with valid low does nothing
    flen = 0; put_ff(6); put_copies(16);
    for (int i = 0; i < flen; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; data_i = fb[i]; sof_i = (i == 0); eof_i = (i == flen-1); crc_ok_i = 1'b1;
    end
    @(negedge clk_i); eof_i = 1'b0; sof_i = 1'b0;
    chk(wake_o, 1'b0, "R11 valid low ignored");

    magic_frame(20, 6, 16, 10); run(1'b1, "R2 basic magic");
    magic_frame(0, 6, 16, 0);   run(1'b1, "R6 sequence at offset 0");
    magic_frame(20, 5, 16, 10); run(1'b1, "R3 five FF sync");
    magic_frame(20, 6, 15, 10); run(1'b1, "R3 fifteen copies");
    magic_frame(20, 9, 16, 10); run(1'b1, "R4 surplus sync bytes");
    magic_frame(20, 6, 16, 10); run(1'b0, "R7 bad CRC");

    // R5: broken copy, then sixteen copies with no new sync
    flen = 0; put_rand(12); put_ff(6); put_copies(3); put(mbyte(0)); put(mbyte(1)); put(8'h5A);
    put_copies(16); put_rand(8);
    run(1'b1, "R5 no restart without sync");
    // R5: broken copy, then a fresh sync and sixteen copies
    flen = 0; put_rand(12); put_ff(6); put_copies(5); put(mbyte(0)); put(8'h5A);
    put_rand(7); put_ff(6); put_copies(16); put_rand(8);
    run(1'b1, "R5 rehunt succeeds");

    // R6: multicast destination
    flen = 0; put(8'h01); put(8'h00); put(8'h5E); put_rand(40); put_ff(6); put_copies(16); put_rand(4);
    run(1'b1, "R6 multicast destination");

    // R8 power states
    magic_frame(10, 6, 16, 5);
    pwr_state_i = 2'b00; mp_en_i = 1'b0; run(1'b1, "R8 full power disabled");
    pwr_state_i = 2'b01; mp_en_i = 1'b0; run(1'b1, "R8 standby auto");
    pwr_state_i = 2'b10; mp_en_i = 1'b1; run(1'b1, "R8 state 10");
    pwr_state_i = 2'b11; mp_en_i = 1'b1; run(1'b1, "R8 state 11");
    pwr_state_i = 2'b00; mp_en_i = 1'b1;

    // R9: sequence split across frames
    clear_wake();
    flen = 0; put_rand(10); put_ff(6); put_copies(8); send(1'b1, 1'b0, 1'b0);
    flen = 0; put_copies(8); put_rand(10); send(1'b1, 1'b0, 1'b0);
    chk(wake_o, 1'b0, "R9 split sequence");

    // R10 sticky, clear, set over clear
    magic_frame(10, 6, 16, 5); clear_wake(); send(1'b1, 1'b0, 1'b0);
    chk(wake_o, 1'b1, "R10 set");
    flen = 0; put_rand(60); send(1'b1, 1'b1, 1'b0);
    chk(wake_o, 1'b1, "R10 sticky");
    clear_wake();
    chk(wake_o, 1'b0, "R10 clear");
    magic_frame(10, 6, 16, 5); send(1'b1, 1'b0, 1'b1);
    chk(wake_o, 1'b1, "R10 set wins over clear");

    // random frames
    prev = wake_o;
    for (int it = 0; it < 250; it++) begin
      bit crc, exp, do_clr;
      int kind;
      for (int k = 0; k < 6; k++) mac_i[47-8*k -: 8] = 8'($urandom_range(0, 254));
      pwr_state_i = 2'($urandom);
      mp_en_i = 1'($urandom);
      crc = ($urandom_range(0, 4) != 0);
      kind = $urandom_range(0, 5);
      flen = 0;
      put_rand($urandom_range(0, 40));
      case (kind)
        0: begin put_ff(6); put_copies(16); end
        1: begin put_ff($urandom_range(7, 10)); put_copies(16); end
        2: begin put_ff(5); put_copies(16); end
        3: begin put_ff(6); put_copies($urandom_range(10, 15)); end
        4: begin put_ff(6); put_copies($urandom_range(1, 8)); put(8'h3C); put_copies(16); end
        default: put_rand(60);
      endcase
      put_rand($urandom_range(0, 20));
      do_clr = 1'($urandom);
      if (do_clr) begin clear_wake(); prev = 1'b0; end
      exp = prev | (model_hit() && crc && model_armed(pwr_state_i, mp_en_i));
      send(crc, 1'b1, 1'b0);
      chk(wake_o, exp, "R2/R3 random frame");
      prev = exp;
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule